// File: doc/BRIEF.md
# Cycle-Steal Word Loader

This block writes one word into main memory by taking a single memory cycle away from the processor. The processor plays no part in the transfer. A host hands over a word address and a data word through a valid/ready pair. The block accepts a word only while the processor reports that it is halted. It then raises a priority-level-0 steal request and waits for the level-0 grant. Once the grant arrives, it drives the shared address and data buses and opens the write-entry gate for a programmed window, so that memory stores the injected word and not the value it read back.

Near the end of the cycle the block releases the request, the buses and the gate together. It then waits until the grant has fallen before it reports the word done and takes the next one. This keeps one word per stolen cycle with no overlap. If no grant comes within a programmed number of clocks, the request is withdrawn and a sticky error flag is raised. That flag clears when the next word is accepted.

All timing is counted in system clocks. The gate offset, the gate width and the length of the driven window are parameters. A full memory cycle of 3.6 us is 450 clocks at 125 MHz.

Top module: `csl_loader`

## Requirements
- R1: `host_ready` is high only when the block is idle and `cpu_halted` is high. While `cpu_halted` is low, a waiting host word is not taken and `steal_req` stays low.
- R2: After a word is accepted, `steal_req` rises on the next cycle and stays high until a grant is seen or the timeout expires.
- R3: `bus_drive` rises only in the cycle after `steal_grant` was sampled high. While it is high, `bus_addr` and `bus_data` carry exactly the accepted address and data.
- R4: `wr_gate` rises GATE_OFS cycles after `bus_drive` rises. It stays high for exactly GATE_LEN cycles, and only while `bus_drive` is high.
- R5: `bus_drive` stays high for CYCLE_CLKS cycles. `steal_req`, `bus_drive` and `wr_gate` then all fall on the same edge.
- R6: `xfer_done` pulses for one cycle only after `steal_grant` has been sampled low. `host_ready` stays low while the grant is still high.
- R7: If no grant arrives within TIMEOUT cycles of request, `steal_req` falls after exactly TIMEOUT cycles high and `grant_err` sets. The flag stays set until the next word is accepted, which clears it.
- R8: With ZERO_IDLE=1, `bus_addr` and `bus_data` read all zeros whenever `bus_drive` is low.
- R9: After reset, `host_ready` follows `cpu_halted` and all other outputs are low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_valid | input | 1 | Host offers a word |
| host_ready | output | 1 | Block will take the offered word |
| host_addr | input | ADDR_W | Word address to write |
| host_data | input | DATA_W | Data word to write |
| cpu_halted | input | 1 | Processor is stopped |
| steal_req | output | 1 | Level-0 cycle-steal request |
| steal_grant | input | 1 | Level-0 cycle-steal active/grant |
| bus_drive | output | 1 | Block owns the shared buses |
| bus_addr | output | ADDR_W | Shared address bus value |
| bus_data | output | DATA_W | Shared data bus value |
| wr_gate | output | 1 | Write-entry gate into memory |
| xfer_done | output | 1 | One-cycle pulse when a word has completed |
| grant_err | output | 1 | Sticky grant-timeout flag |

## Verification
The bench holds a word while the processor runs. A loader that ignored the halt input would request a cycle the processor still owns. The bench changes grant latency between words and measures the gate offset, the gate width and the drive length for each word. An off-by-one counter would open the gate one clock early or late, or would clip the driven window. It keeps the grant high for two clocks after release. A design that finished on release, and not on grant fall, would pulse done or raise ready while the grant was still active. In the timeout case it counts the request cycles exactly and checks that the error clears on the next accepted word.

// File: rtl/csl_pkg.sv
package csl_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_REQ     = 2'd1,
      ST_CYCLE   = 2'd2,
      ST_RELEASE = 2'd3
   } csl_state_e;

   function automatic int csl_cnt_w(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction
endpackage

// File: rtl/csl_word_latch.sv
module csl_word_latch #(
   parameter int ADDR_W    = 15,
   parameter int DATA_W    = 16,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic              drive,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data
);
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (load) begin
         addr_q <= addr_in;
         data_q <= data_in;
      end
   end

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         always_comb begin
            bus_addr = drive ? addr_q : '0;
            bus_data = drive ? data_q : '0;
         end
      end else begin : g_hold_idle
         logic unused_drive;
         assign unused_drive = drive;
         always_comb begin
            bus_addr = addr_q;
            bus_data = data_q;
         end
      end
   endgenerate

   p_bus_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (drive && $past(drive) && !load) |-> ($stable(bus_addr) && $stable(bus_data)));
endmodule

// File: rtl/csl_cycle_timer.sv
module csl_cycle_timer #(
   parameter int CYCLE_CLKS = 450,
   parameter int GATE_OFS   = 150,
   parameter int GATE_LEN   = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic gate_win,
   output logic last
);
   localparam int CW = csl_pkg::csl_cnt_w(CYCLE_CLKS);
   localparam logic [CW-1:0] OFS_C  = CW'(GATE_OFS);
   localparam logic [CW-1:0] END_C  = CW'(GATE_OFS + GATE_LEN);
   localparam logic [CW-1:0] LAST_C = CW'(CYCLE_CLKS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run)
         cnt_q <= '0;
      else if (cnt_q != LAST_C)
         cnt_q <= cnt_q + 1'b1;
   end

   always_comb begin
      gate_win = run && (cnt_q >= OFS_C) && (cnt_q < END_C);
      last     = run && (cnt_q == LAST_C);
   end

   // the gate window length, counted independently of the window compare
   logic [CW-1:0] gate_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         gate_run_q <= '0;
      else if (gate_win)
         gate_run_q <= gate_run_q + 1'b1;
      else
         gate_run_q <= '0;
   end

   p_gate_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gate_win |-> (gate_run_q < CW'(GATE_LEN)));
   p_gate_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_win && (gate_run_q != '0)) |-> (gate_run_q == CW'(GATE_LEN)));
endmodule

// File: rtl/csl_grant_watchdog.sv
module csl_grant_watchdog #(
   parameter int TIMEOUT = 4096
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic grant,
   output logic expire
);
   localparam int WW = csl_pkg::csl_cnt_w(TIMEOUT);
   localparam logic [WW-1:0] LIM_C = WW'(TIMEOUT - 1);

   logic [WW-1:0] wait_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wait_q <= '0;
      else if (!arm || grant)
         wait_q <= '0;
      else if (wait_q != LIM_C)
         wait_q <= wait_q + 1'b1;
   end

   assign expire = arm && !grant && (wait_q == LIM_C);

   p_expire_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> $past(arm));
endmodule

// File: rtl/csl_loader.sv
module csl_loader #(
   parameter int ADDR_W     = 15,
   parameter int DATA_W     = 16,
   parameter int CYCLE_CLKS = 450,
   parameter int GATE_OFS   = 150,
   parameter int GATE_LEN   = 200,
   parameter int TIMEOUT    = 4096,
   parameter bit ZERO_IDLE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_valid,
   output logic              host_ready,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0] host_data,
   input  logic              cpu_halted,
   output logic              steal_req,
   input  logic              steal_grant,
   output logic              bus_drive,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              wr_gate,
   output logic              xfer_done,
   output logic              grant_err
);
   import csl_pkg::*;

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("csl_loader: bus widths must be positive");
      end
      if (GATE_LEN < 1) begin : g_bad_gate
         $error("csl_loader: gate width must be at least one clock");
      end
      if (GATE_OFS + GATE_LEN > CYCLE_CLKS) begin : g_bad_window
         $error("csl_loader: gate window exceeds driven cycle");
      end
      if (TIMEOUT < 1) begin : g_bad_timeout
         $error("csl_loader: timeout must be at least one clock");
      end
   endgenerate

   csl_state_e st_q, st_d;
   logic       accept, gate_win, cyc_last, expire;
   logic       done_q, err_q;

   assign accept = host_valid && host_ready;

   csl_word_latch #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ZERO_IDLE(ZERO_IDLE)
   ) u_latch (
      .clk(clk), .rst_n(rst_n), .load(accept),
      .addr_in(host_addr), .data_in(host_data),
      .drive(bus_drive), .bus_addr(bus_addr), .bus_data(bus_data)
   );

   csl_cycle_timer #(
      .CYCLE_CLKS(CYCLE_CLKS), .GATE_OFS(GATE_OFS), .GATE_LEN(GATE_LEN)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .run(st_q == ST_CYCLE),
      .gate_win(gate_win), .last(cyc_last)
   );

   csl_grant_watchdog #(
      .TIMEOUT(TIMEOUT)
   ) u_wdog (
      .clk(clk), .rst_n(rst_n), .arm(st_q == ST_REQ),
      .grant(steal_grant), .expire(expire)
   );

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:    if (accept) st_d = ST_REQ;
         ST_REQ:     if (steal_grant) st_d = ST_CYCLE;
                     else if (expire) st_d = ST_IDLE;
         ST_CYCLE:   if (cyc_last || !steal_grant) st_d = ST_RELEASE;
         ST_RELEASE: if (!steal_grant) st_d = ST_IDLE;
         default:    st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= (st_q == ST_RELEASE) && !steal_grant;
         if (accept)
            err_q <= 1'b0;
         else if (st_q == ST_REQ && !steal_grant && expire)
            err_q <= 1'b1;
      end
   end

   always_comb begin
      host_ready = (st_q == ST_IDLE) && cpu_halted;
      steal_req  = (st_q == ST_REQ) || (st_q == ST_CYCLE);
      bus_drive  = (st_q == ST_CYCLE);
      wr_gate    = gate_win;
      xfer_done  = done_q;
      grant_err  = err_q;
   end

   p_ready_halted_r1: assert property (@(posedge clk) disable iff (!rst_n)
      host_ready |-> cpu_halted);
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (steal_req && !bus_drive && !steal_grant && !expire) |=> steal_req);
   p_drive_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_drive) |-> $past(steal_grant));
   p_gate_in_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_gate |-> bus_drive);
   p_release_together_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_drive) |-> (!steal_req && !wr_gate));
   p_done_after_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> ($past(!steal_grant) && !bus_drive));
   p_ready_no_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_drive || $past(bus_drive)) |-> !host_ready);
   p_err_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_err) |-> !steal_req);
endmodule

// File: tb/csl_loader_bench.sv
module csl_loader_bench;
   localparam int AW = 15, DW = 16;
   localparam int CYC = 12, OFS = 3, LEN = 5, TMO = 24;

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_valid = 1'b0, cpu_halted = 1'b0, steal_grant = 1'b0;
   logic [AW-1:0] host_addr = '0;
   logic [DW-1:0] host_data = '0;
   logic host_ready, steal_req, bus_drive, wr_gate, xfer_done, grant_err;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_data;

   int checks = 0, fails = 0;
   int resp_lat = 2;
   bit resp_en = 1'b1;
   logic [AW+DW-1:0] expq[$];

   always #4 clk = ~clk;

   csl_loader #(.ADDR_W(AW), .DATA_W(DW), .CYCLE_CLKS(CYC), .GATE_OFS(OFS),
                .GATE_LEN(LEN), .TIMEOUT(TMO), .ZERO_IDLE(1'b1)) u_csl_loader (
      .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
      .host_addr(host_addr), .host_data(host_data), .cpu_halted(cpu_halted),
      .steal_req(steal_req), .steal_grant(steal_grant), .bus_drive(bus_drive),
      .bus_addr(bus_addr), .bus_data(bus_data), .wr_gate(wr_gate),
      .xfer_done(xfer_done), .grant_err(grant_err));

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // grant responder: memory-side arbiter model
   initial begin
      forever begin
         @(negedge clk);
         if (steal_req && resp_en && !steal_grant) begin
            repeat (resp_lat) @(negedge clk);
            chk(steal_req == 1'b1, "R2 req held until grant", steal_req, 1);
            steal_grant = 1'b1;
            while (steal_req) @(negedge clk);
            repeat (2) @(negedge clk);
            steal_grant = 1'b0;
         end
      end
   end

   // monitor: scoreboard consumer
   int drv_n = 0, pre_n = 0, gate_n = 0;
   bit gate_seen = 0, prev_drive = 0;
   logic [AW-1:0] cap_a;
   logic [DW-1:0] cap_d;
   initial begin
      forever begin
         @(negedge clk);
         if (bus_drive) begin
            drv_n++;
            if (wr_gate) begin
               if (!gate_seen) begin cap_a = bus_addr; cap_d = bus_data; end
               gate_seen = 1;
               gate_n++;
            end else if (!gate_seen) pre_n++;
         end else if (prev_drive) begin
            logic [AW+DW-1:0] e;
            chk(drv_n == CYC, "R5 drive length", drv_n, CYC);
            chk(!steal_req && !wr_gate, "R5 release together", {steal_req, wr_gate}, 0);
            chk(pre_n == OFS, "R4 gate offset", pre_n, OFS);
            chk(gate_n == LEN, "R4 gate width", gate_n, LEN);
            chk(bus_addr == '0 && bus_data == '0, "R8 idle bus zero", {bus_addr, bus_data}, 0);
            chk(!host_ready && steal_grant, "R6 no ready while granted", host_ready, 0);
            if (expq.size() == 0) chk(0, "R3 unexpected transfer", {cap_a, cap_d}, 0);
            else begin
               e = expq.pop_front();
               chk({cap_a, cap_d} == e, "R3 bus word", {cap_a, cap_d}, e);
            end
            drv_n = 0; pre_n = 0; gate_n = 0; gate_seen = 0;
         end
         if (xfer_done)
            chk(!steal_grant, "R6 done after grant fall", steal_grant, 0);
         prev_drive = bus_drive;
      end
   end

   task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit expect_ok);
      int guard = 0;
      @(negedge clk);
      while (!host_ready) @(negedge clk);
      host_valid = 1'b1; host_addr = a; host_data = d;
      if (expect_ok) expq.push_back({a, d});
      @(negedge clk);
      host_valid = 1'b0;
      while (!xfer_done && !grant_err && guard < 1000) begin
         @(negedge clk); guard++;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!host_ready && !steal_req && !bus_drive && !wr_gate && !xfer_done && !grant_err,
          "R9 reset outputs", {host_ready, steal_req, bus_drive, wr_gate, xfer_done, grant_err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus_addr == '0 && bus_data == '0, "R9 reset buses", {bus_addr, bus_data}, 0);
      // R1: processor running, offered word must be held off
      host_valid = 1'b1; host_addr = 15'h1111; host_data = 16'h2222;
      begin
         bit any_ready = 0, any_req = 0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (host_ready) any_ready = 1;
            if (steal_req) any_req = 1;
         end
         chk(!any_ready, "R1 no ready while running", any_ready, 0);
         chk(!any_req, "R1 no request while running", any_req, 0);
      end
      host_valid = 1'b0;
      cpu_halted = 1'b1;
      @(negedge clk);
      chk(host_ready, "R9 ready follows halted", host_ready, 1);
      resp_lat = 1; send(15'h7FFF, 16'hFFFF, 1);
      chk(xfer_done, "R6 done pulse", xfer_done, 1);
      @(negedge clk);
      chk(!xfer_done, "R6 done single cycle", xfer_done, 0);
      resp_lat = 3; send(15'h2AAA, 16'h5555, 1);
      resp_lat = 6; send(15'h0001, 16'h8001, 1);
      resp_lat = 2; send(15'h4000, 16'h1234, 1);
      // R7 timeout
      resp_en = 1'b0;
      begin
         int req_n = 0;
         @(negedge clk);
         while (!host_ready) @(negedge clk);
         host_valid = 1'b1; host_addr = 15'h0555; host_data = 16'hAAAA;
         @(negedge clk);
         host_valid = 1'b0;
         for (int i = 0; i < TMO + 10; i++) begin
            if (steal_req) req_n++;
            @(negedge clk);
         end
         chk(req_n == TMO, "R7 request length before timeout", req_n, TMO);
         chk(grant_err && !steal_req, "R7 error set and request dropped", {grant_err, steal_req}, 2'b10);
         chk(!bus_drive && !wr_gate, "R7 no drive on timeout", {bus_drive, wr_gate}, 0);
      end
      resp_en = 1'b1;
      @(negedge clk);
      while (!host_ready) @(negedge clk);
      host_valid = 1'b1; host_addr = 15'h3C3C; host_data = 16'h0F0F;
      expq.push_back({15'h3C3C, 16'h0F0F});
      @(negedge clk);
      host_valid = 1'b0;
      chk(!grant_err, "R7 error cleared on accept", grant_err, 0);
      while (!xfer_done) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(expq.size() == 0, "R3 all words written", expq.size(), 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule